// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is one general-purpose I/O port of up to eight pins. Software configures every pin through a small register interface. A pin can be an input, a push-pull output, an open-drain output, or a pin handed over to an on-chip peripheral. The pad side receives an output value and an output-enable for each pin and returns the pad level for each pin. A pull-enable bit for each pin is stored and passed straight to the pad.

Every pin input goes through a two-flop synchroniser. A small state machine for each pin then watches it for one of four trigger conditions, chosen per pin: rising edge, falling edge, low level or high level. A match sets the pin's pending flag. The port has one interrupt line, which is high whenever any pending pin also has its enable bit set. Software reads the pending flags and clears edge-triggered flags by writing ones.

Each pin's detector state machine has two states. `EV_IDLE` means no event is pending. `EV_PEND` means the pin has an event waiting.
- In edge mode, `EV_IDLE -> EV_PEND` happens when the selected edge is seen. `EV_PEND -> EV_IDLE` happens on a write-one-clear, unless a new edge arrives in the same cycle.
- In level mode, the state follows the level match every cycle: `EV_PEND` while the selected level is present, `EV_IDLE` otherwise.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, all registers and all pending flags read 0, every `pad_oe` bit is 0, `pad_pull_en` is 0 and `irq` is 0. The trigger mode defaults to rising edge.
- R2: The register map uses 4-bit addresses:
  - 0 output data
  - 1 direction (1 = output)
  - 2 open-drain select
  - 3 alternate-function select
  - 4 interrupt enable
  - 5 trigger kind (1 = level, 0 = edge)
  - 6 trigger polarity (edge: 0 = rising, 1 = falling; level: 0 = low, 1 = high)
  - 7 pending (read; writing 1 clears)
  - 8 pull enable
  - 9 synchronised pin levels (read only)

  Registers 0–6 and 8 read back what was written. Any other address reads 0.
- R3: A non-alternate push-pull pin drives `pad_out` from its data bit. Its `pad_oe` equals its direction bit.
- R4: A non-alternate open-drain pin drives `pad_out` = 0. Its `pad_oe` is 1 only when the pin is an output and its data bit is 0.
- R5: A pin with alternate function selected takes `pad_out` and `pad_oe` from `periph_out` and `periph_oe`, whatever its direction, open-drain and data bits are.
- R6: A change on `pad_in` shows in register 9 after two clock edges. An event it causes shows in the pending flags after three clock edges.
- R7: In rising-edge mode, a 0→1 input transition sets the pending flag. The flag stays set after the input returns to 0 and clears when a 1 is written to it.
- R8: In falling-edge mode, a 1→0 transition sets the pending flag. A rising transition does not.
- R9: In level mode, the pending flag is 1 exactly while the synchronised input matches the selected level. A write-one-clear has no effect while the level persists.
- R10: `irq` is the OR over pins of (pending AND enable). A pending flag is set whether or not the pin's enable bit is set.
- R11: With `NPINS` = 6, the registers and pins are six bits wide, so a write of all ones reads back as 0x3F.
- R12: `pad_pull_en` equals the pull-enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | NPINS | Write data, one bit per pin |
| reg_rdata | output | NPINS | Read data for `reg_addr` (combinational) |
| pad_in | input | NPINS | Pad input levels (asynchronous) |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_pull_en | output | NPINS | Pull enable passed to the pads |
| periph_out | input | NPINS | Peripheral output values for alternate-function pins |
| periph_oe | input | NPINS | Peripheral output enables for alternate-function pins |
| irq | output | 1 | Port interrupt line |

## Verification
A detector stuck in the wrong state, or a lost previous-value flop, shows up three edges after the pin stimulus. It appears either as a pending bit in register 7 that should not be there, or as a missing one, and `irq` follows in the same cycle. Stickiness faults only appear later: they show after the pin returns to idle, or at the first readback after a write-one-clear. Configuration register faults show at once, because they are combinational, on `pad_out` and `pad_oe`.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        RA_DOUT   = 4'd0,
        RA_DIR    = 4'd1,
        RA_ODRAIN = 4'd2,
        RA_ALTFN  = 4'd3,
        RA_IEN    = 4'd4,
        RA_TKIND  = 4'd5,
        RA_TPOL   = 4'd6,
        RA_PEND   = 4'd7,
        RA_PULL   = 4'd8,
        RA_PINS   = 4'd9
    } reg_addr_e;

    typedef enum logic {
        EV_IDLE = 1'b0,
        EV_PEND = 1'b1
    } ev_state_e;

    typedef struct packed {
        logic level;   // 1 = level trigger, 0 = edge trigger
        logic pol;     // edge: 0 rise / 1 fall; level: 0 low / 1 high
    } trig_cfg_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= '0;
        end else begin
            chain_q[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[s] <= '0;
            end else begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event
    import gpio_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_s,
    input  trig_cfg_t cfg,
    input  logic      clr,
    output logic      pend
);

    logic      prev_q;
    logic      edge_hit;
    logic      level_hit;
    ev_state_e state_q;
    ev_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
        end
    end

    always_comb begin
        edge_hit  = cfg.pol ? (prev_q & ~pin_s) : (~prev_q & pin_s);
        level_hit = (pin_s == cfg.pol);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cfg.level) begin
            state_d = level_hit ? EV_PEND : EV_IDLE;
        end else begin
            unique case (state_q)
                EV_IDLE: if (edge_hit)          state_d = EV_PEND;
                EV_PEND: if (clr && !edge_hit)  state_d = EV_IDLE;
                default:                        state_d = EV_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        pend = (state_q == EV_PEND);
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  pins_s,
    input  logic [NPINS-1:0]  pend,
    output logic [NPINS-1:0]  dout,
    output logic [NPINS-1:0]  dir,
    output logic [NPINS-1:0]  odrain,
    output logic [NPINS-1:0]  altfn,
    output logic [NPINS-1:0]  ien,
    output logic [NPINS-1:0]  tkind,
    output logic [NPINS-1:0]  tpol,
    output logic [NPINS-1:0]  pull,
    output logic [NPINS-1:0]  clr
);

    reg_addr_e addr;
    assign addr = reg_addr_e'(reg_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout   <= '0;
            dir    <= '0;
            odrain <= '0;
            altfn  <= '0;
            ien    <= '0;
            tkind  <= '0;
            tpol   <= '0;
            pull   <= '0;
        end else if (reg_wr) begin
            case (addr)
                RA_DOUT:   dout   <= reg_wdata;
                RA_DIR:    dir    <= reg_wdata;
                RA_ODRAIN: odrain <= reg_wdata;
                RA_ALTFN:  altfn  <= reg_wdata;
                RA_IEN:    ien    <= reg_wdata;
                RA_TKIND:  tkind  <= reg_wdata;
                RA_TPOL:   tpol   <= reg_wdata;
                RA_PULL:   pull   <= reg_wdata;
                default:   ;
            endcase
        end
    end

    assign clr = (reg_wr && addr == RA_PEND) ? reg_wdata : '0;

    always_comb begin
        case (addr)
            RA_DOUT:   reg_rdata = dout;
            RA_DIR:    reg_rdata = dir;
            RA_ODRAIN: reg_rdata = odrain;
            RA_ALTFN:  reg_rdata = altfn;
            RA_IEN:    reg_rdata = ien;
            RA_TKIND:  reg_rdata = tkind;
            RA_TPOL:   reg_rdata = tpol;
            RA_PEND:   reg_rdata = pend;
            RA_PULL:   reg_rdata = pull;
            RA_PINS:   reg_rdata = pins_s;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] dout,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] odrain,
    input  logic [NPINS-1:0] altfn,
    input  logic [NPINS-1:0] periph_out,
    input  logic [NPINS-1:0] periph_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign pad_out[i] = altfn[i]  ? periph_out[i] :
                            odrain[i] ? 1'b0 : dout[i];
        assign pad_oe[i]  = altfn[i]  ? periph_oe[i] :
                            odrain[i] ? (dir[i] & ~dout[i]) : dir[i];
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pull_en,
    input  logic [NPINS-1:0]  periph_out,
    input  logic [NPINS-1:0]  periph_oe,
    output logic              irq
);

    logic [NPINS-1:0] dout_q, dir_q, od_q, af_q, ien_q, kind_q, pol_q;
    logic [NPINS-1:0] pend_q, pin_s, clr_vec;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_s)
    );

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pins_s    (pin_s),
        .pend      (pend_q),
        .dout      (dout_q),
        .dir       (dir_q),
        .odrain    (od_q),
        .altfn     (af_q),
        .ien       (ien_q),
        .tkind     (kind_q),
        .tpol      (pol_q),
        .pull      (pad_pull_en),
        .clr       (clr_vec)
    );

    gpio_pad_mux #(.NPINS(NPINS)) u_mux (
        .dout       (dout_q),
        .dir        (dir_q),
        .odrain     (od_q),
        .altfn      (af_q),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_evt
        trig_cfg_t cfg;
        assign cfg = '{level: kind_q[i], pol: pol_q[i]};

        gpio_pin_event u_evt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_s (pin_s[i]),
            .cfg   (cfg),
            .clr   (clr_vec[i]),
            .pend  (pend_q[i])
        );
    end

    assign irq = |(pend_q & ien_q);

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic             irq,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] od_q,
    input logic [NPINS-1:0] af_q,
    input logic [NPINS-1:0] ien_q,
    input logic [NPINS-1:0] kind_q,
    input logic [NPINS-1:0] pol_q,
    input logic [NPINS-1:0] pend_q,
    input logic [NPINS-1:0] pin_s,
    input logic [NPINS-1:0] clr_vec
);

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // R4
        od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!af_q[i] && od_q[i]) |-> !(pad_oe[i] && pad_out[i]));

        // R3
        input_not_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!af_q[i] && !dir_q[i]) |-> !pad_oe[i]);

        // R7
        edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!kind_q[i] && pend_q[i] && !clr_vec[i]) |=> pend_q[i]);

        // R7
        rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!kind_q[i] && !pol_q[i] && $rose(pin_s[i])) |=> pend_q[i]);

        // R8
        fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!kind_q[i] && pol_q[i] && $fell(pin_s[i])) |=> pend_q[i]);

        // R9
        level_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
            kind_q[i] |=> (pend_q[i] == ($past(pin_s[i]) == $past(pol_q[i]))));
    end

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .irq     (irq),
    .dir_q   (dir_q),
    .od_q    (od_q),
    .af_q    (af_q),
    .ien_q   (ien_q),
    .kind_q  (kind_q),
    .pol_q   (pol_q),
    .pend_q  (pend_q),
    .pin_s   (pin_s),
    .clr_vec (clr_vec)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pull_en;
    logic [7:0] periph_out = '0;
    logic [7:0] periph_oe = '0;
    logic       irq;

    logic [5:0] s_rdata, s_out, s_oe, s_pull;
    logic       s_irq;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_irq_port u_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .periph_out(periph_out), .periph_oe(periph_oe), .irq(irq)
    );

    gpio_irq_port #(.NPINS(6)) u_small (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata[5:0]), .reg_rdata(s_rdata), .pad_in(pad_in[5:0]),
        .pad_out(s_out), .pad_oe(s_oe), .pad_pull_en(s_pull),
        .periph_out(periph_out[5:0]), .periph_oe(periph_oe[5:0]), .irq(s_irq)
    );

    // {dir, odrain, altfn, dout, periph_out, periph_oe, exp_out, exp_oe}
    localparam logic [63:0] OUT_TAB [6] = '{
        64'hF0_00_00_A5_00_00_A5_F0,
        64'hFF_0F_00_36_00_00_30_F9,
        64'h00_00_00_FF_00_00_FF_00,
        64'h00_FF_FF_00_5A_C3_5A_C3,
        64'hFF_00_0F_F0_0C_03_FC_F3,
        64'hAA_AA_00_0F_00_00_05_A0
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            chk("R1 reg reset", v, 8'h00);
        end
        chk("R1 pad_oe reset", pad_oe, 8'h00);
        chk("R1 pull reset", pad_pull_en, 8'h00);
        chk("R1 irq reset", {7'd0, irq}, 8'h00);

        // R2 readback
        for (int a = 0; a < 9; a++) begin
            if (a == 7) continue;
            wr(4'(a), 8'(8'h11 * (a + 1)));
            rd(4'(a), v);
            chk("R2 readback", v, 8'(8'h11 * (a + 1)));
        end
        rd(4'd10, v);
        chk("R2 unmapped", v, 8'h00);
        for (int a = 0; a < 9; a++) begin
            if (a != 7) wr(4'(a), 8'h00);
        end

        // R3 R4 R5 pad muxing from table
        for (int k = 0; k < 6; k++) begin
            logic [63:0] e;
            e = OUT_TAB[k];
            wr(4'd1, e[63:56]);
            wr(4'd2, e[55:48]);
            wr(4'd3, e[47:40]);
            wr(4'd0, e[39:32]);
            periph_out = e[31:24];
            periph_oe  = e[23:16];
            step(1);
            chk("R3/R4/R5 pad_out", pad_out, e[15:8]);
            chk("R3/R4/R5 pad_oe", pad_oe, e[7:0]);
        end
        wr(4'd1, 8'h00);
        wr(4'd2, 8'h00);
        wr(4'd3, 8'h00);
        periph_out = '0;
        periph_oe  = '0;

        // R12 pull passthrough
        wr(4'd8, 8'h3C);
        chk("R12 pull", pad_pull_en, 8'h3C);
        chk("R12 pull small", {2'b00, s_pull}, 8'h3C);

        // R11 narrow instance
        wr(4'd0, 8'hFF);
        reg_addr = 4'd0;
        #1;
        chk("R11 small width", {2'b00, s_rdata}, 8'h3F);
        chk("R11 full width", reg_rdata, 8'hFF);
        wr(4'd0, 8'h00);

        // R6 R7 rising edge on pin 0
        wr(4'd4, 8'h01);
        pad_in[0] = 1'b1;
        step(1);
        rd(4'd9, v);
        chk("R6 pins after one edge", v, 8'h00);
        step(1);
        rd(4'd9, v);
        chk("R6 pins after two edges", v, 8'h01);
        rd(4'd7, v);
        chk("R6 pend not yet", v, 8'h00);
        step(1);
        rd(4'd7, v);
        chk("R7 rise pending", v, 8'h01);
        chk("R10 irq on", {7'd0, irq}, 8'h01);
        pad_in[0] = 1'b0;
        step(4);
        rd(4'd7, v);
        chk("R7 sticky", v, 8'h01);
        wr(4'd7, 8'h01);
        rd(4'd7, v);
        chk("R7 cleared", v, 8'h00);
        chk("R7 irq off", {7'd0, irq}, 8'h00);

        // R8 falling edge on pin 1
        wr(4'd6, 8'h02);
        pad_in[1] = 1'b1;
        step(4);
        rd(4'd7, v);
        chk("R8 rise ignored", v, 8'h00);
        pad_in[1] = 1'b0;
        step(3);
        rd(4'd7, v);
        chk("R8 fall pending", v, 8'h02);
        chk("R10 masked irq", {7'd0, irq}, 8'h00);
        wr(4'd4, 8'h03);
        chk("R10 enabled irq", {7'd0, irq}, 8'h01);
        wr(4'd7, 8'h02);
        rd(4'd7, v);
        chk("R8 cleared", v, 8'h00);

        // R9 high level on pin 2
        wr(4'd6, 8'h06);
        wr(4'd5, 8'h04);
        step(2);
        rd(4'd7, v);
        chk("R9 high level idle", v, 8'h00);
        pad_in[2] = 1'b1;
        step(3);
        rd(4'd7, v);
        chk("R9 high level pending", v, 8'h04);
        wr(4'd7, 8'h04);
        step(1);
        rd(4'd7, v);
        chk("R9 clear ignored", v, 8'h04);
        pad_in[2] = 1'b0;
        step(3);
        rd(4'd7, v);
        chk("R9 level released", v, 8'h00);

        // R9 low level on pin 3
        wr(4'd5, 8'h0C);
        step(1);
        rd(4'd7, v);
        chk("R9 low level pending", v, 8'h08);
        pad_in[3] = 1'b1;
        step(3);
        rd(4'd7, v);
        chk("R9 low level released", v, 8'h00);

        // R10 shared line, pins 4 and 5
        wr(4'd4, 8'h30);
        pad_in[5:4] = 2'b11;
        step(3);
        rd(4'd7, v);
        chk("R10 two pending", v, 8'h30);
        chk("R10 irq shared", {7'd0, irq}, 8'h01);
        wr(4'd7, 8'h10);
        chk("R10 irq one left", {7'd0, irq}, 8'h01);
        wr(4'd7, 8'h20);
        chk("R10 irq all cleared", {7'd0, irq}, 8'h00);

        // R1 reset mid-run
        rst_n = 1'b0;
        #1;
        rd(4'd7, v);
        chk("R1 pend after reset", v, 8'h00);
        rd(4'd4, v);
        chk("R1 ien after reset", v, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);

        summary();
        $finish;
    end

endmodule